// File: doc/BRIEF.md
# TLP Parity Screen with Error Reporting

This block sits where a switch port consumes TLPs. Each beat of an incoming TLP carries one parity bit per data byte. The block checks every beat. It holds each TLP in a store-and-forward buffer until the end beat has arrived and been checked. A TLP that passes is released on the output stream. A TLP with a mismatch on any of its beats is thrown away as a whole.

Every dropped TLP is counted in a saturating error counter. Unless reporting is silenced, a dropped TLP also sets a sticky detected-parity status flag. When the message enable is on and reporting is not silenced, it raises a one-cycle request for a non-fatal error message toward the root. Once the counter has saturated, no further message requests are raised, so a stream of corrupt TLPs cannot flood the root. A read strobe returns the counter and the status flag together and clears both.

Top module: `tlp_parity_guard`

## Requirements
- R1: Parity is even with one bit per byte. Bit `in_par[i]` equals the XOR of `in_data[8i+7:8i]`. A TLP whose beats all match is forwarded unchanged, with the same beat order and the same start and end markers. Its first beat appears on the output in the cycle after its end beat was accepted, and the rest follow one beat per cycle.
- R2: A TLP with a parity mismatch on any beat (first, middle or last) produces no output beat at all. TLPs before and after it are still forwarded.
- R3: Each dropped TLP adds one to the error count in `reg_rd_data[7:0]`, whether or not reporting is silenced.
- R4: The error count stops at 255. An error seen while the count is already 255 raises no message request.
- R5: `msg_req` is a single-cycle pulse in the cycle after the end beat of a dropped TLP. It is raised only when `cfg_msg_en` is 1 and `cfg_silent` is 0 in that end-beat cycle.
- R6: When `cfg_silent` is 1, a dropped TLP neither sets the status flag in `reg_rd_data[8]` nor requests a message.
- R7: With `cfg_silent` at 0, a dropped TLP sets the status flag `reg_rd_data[8]`, which stays set until read.
- R8: In a cycle with `reg_rd` high, `reg_rd_data` shows the value held before that cycle, and the count and status are cleared at the next edge. If an error lands in the same cycle as the read, the read shows the old value and the count is left at 1.
- R9: After reset, `out_valid`, `msg_req` and `reg_rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | First beat of a TLP |
| in_eop | input | 1 | Last beat of a TLP |
| in_data | input | 32 | Input beat data |
| in_par | input | 4 | Even parity, one bit per byte |
| cfg_silent | input | 1 | Silences status and message on errors |
| cfg_msg_en | input | 1 | Enables non-fatal message requests |
| reg_rd | input | 1 | Read strobe; clears count and status |
| reg_rd_data | output | 9 | {status, error count} |
| msg_req | output | 1 | One-cycle non-fatal message request |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | First beat of a forwarded TLP |
| out_eop | output | 1 | Last beat of a forwarded TLP |
| out_data | output | 32 | Output beat data |

## Verification
The assertions take for granted several things about the input. Every TLP is framed, with a start beat before its end beat. No TLP is longer than half the buffer depth. The control inputs hold steady around the end beat they qualify. The bench uses a single driver task that always frames TLPs properly and sends at most 16 beats. It changes `cfg_silent` and `cfg_msg_en` only while the input is idle. It waits for the output to drain before starting each new scenario, so the buffer can never overrun.

// File: rtl/tlp_parity_guard_pkg.sv
package tlp_parity_guard_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic int unsigned lanes_of(int unsigned data_w);
    return data_w / BYTE_W;
  endfunction
endpackage

// File: rtl/tpg_parity_scan.sv
module tpg_parity_scan
  import tlp_parity_guard_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NB = DATA_W / BYTE_W
) (
  input  logic [DATA_W-1:0] data,
  input  logic [NB-1:0]     par,
  output logic              mismatch
);
  logic [NB-1:0] lane_bad;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_bad[g] = (^data[g*BYTE_W +: BYTE_W]) ^ par[g];
  end

  assign mismatch = |lane_bad;
endmodule

// File: rtl/tpg_tlp_store.sv
module tpg_tlp_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned EW = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              keep,
  input  logic              discard,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_n;
  logic [AW-1:0] cm_ptr_q, cm_ptr_n;
  logic [AW-1:0] rd_ptr_q, rd_ptr_n;
  logic [EW-1:0] head;

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    cm_ptr_n = cm_ptr_q;
    if (wr_en) wr_ptr_n = wr_ptr_q + 1'b1;
    if (keep) cm_ptr_n = wr_ptr_q + 1'b1;
    if (discard) wr_ptr_n = cm_ptr_q;
  end

  assign out_valid = (rd_ptr_q != cm_ptr_q);
  assign rd_ptr_n  = out_valid ? rd_ptr_q + 1'b1 : rd_ptr_q;
  assign head      = mem[rd_ptr_q];
  assign out_sop   = head[EW-1];
  assign out_eop   = head[EW-2];
  assign out_data  = head[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= {wr_sop, wr_eop, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      cm_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      cm_ptr_q <= cm_ptr_n;
      rd_ptr_q <= rd_ptr_n;
    end
  end
endmodule

// File: rtl/tpg_err_report.sv
module tpg_err_report #(
  parameter int unsigned CNT_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bad_evt,
  input  logic           silent,
  input  logic           msg_en,
  input  logic           rd,
  output logic [CNT_W:0] rd_data,
  output logic           msg_req
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             sts_q, sts_n;
  logic             msg_n;
  logic             sat;

  assign sat = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_n = cnt_q;
    if (rd) cnt_n = bad_evt ? CNT_W'(1) : '0;
    else if (bad_evt && !sat) cnt_n = cnt_q + 1'b1;
    sts_n = (bad_evt && !silent) || (sts_q && !rd);
    msg_n = bad_evt && !silent && msg_en && !sat;
  end

  assign rd_data = {sts_q, cnt_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sts_q   <= 1'b0;
      msg_req <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      sts_q   <= sts_n;
      msg_req <= msg_n;
    end
  end
endmodule

// File: rtl/tlp_parity_guard.sv
module tlp_parity_guard
  import tlp_parity_guard_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned NB = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  input  logic [NB-1:0]     in_par,
  input  logic              cfg_silent,
  input  logic              cfg_msg_en,
  input  logic              reg_rd,
  output logic [CNT_W:0]    reg_rd_data,
  output logic              msg_req,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data
);
  logic beat_bad;
  logic acc_q, acc_n;
  logic tlp_bad;
  logic tlp_good;
  logic prior_bad;

  tpg_parity_scan #(.DATA_W(DATA_W)) u_scan (
    .data     (in_data),
    .par      (in_par),
    .mismatch (beat_bad)
  );

  assign prior_bad = in_sop ? 1'b0 : acc_q;
  assign tlp_bad   = in_valid && in_eop && (prior_bad || beat_bad);
  assign tlp_good  = in_valid && in_eop && !(prior_bad || beat_bad);

  always_comb begin
    acc_n = acc_q;
    if (in_valid) acc_n = in_eop ? 1'b0 : (prior_bad || beat_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 1'b0;
    else        acc_q <= acc_n;
  end

  tpg_tlp_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (in_valid),
    .wr_sop    (in_sop),
    .wr_eop    (in_eop),
    .wr_data   (in_data),
    .keep      (tlp_good),
    .discard   (tlp_bad),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_data  (out_data)
  );

  tpg_err_report #(.CNT_W(CNT_W)) u_rep (
    .clk     (clk),
    .rst_n   (rst_n),
    .bad_evt (tlp_bad),
    .silent  (cfg_silent),
    .msg_en  (cfg_msg_en),
    .rd      (reg_rd),
    .rd_data (reg_rd_data),
    .msg_req (msg_req)
  );
endmodule

// File: rtl/tlp_parity_guard_chk.sv
module tlp_parity_guard_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_eop,
  input logic           cfg_silent,
  input logic           cfg_msg_en,
  input logic           reg_rd,
  input logic [CNT_W:0] reg_rd_data,
  input logic           msg_req,
  input logic           tlp_bad
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R5
  msg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> $past(cfg_msg_en && !cfg_silent && in_valid && in_eop));

  // R4
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[CNT_W-1:0] == CMAX && !reg_rd) |=> (reg_rd_data[CNT_W-1:0] == CMAX));

  // R4
  sat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[CNT_W-1:0] == CMAX && !reg_rd) |=> !msg_req);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tlp_bad && !reg_rd && reg_rd_data[CNT_W-1:0] != CMAX)
      |=> (reg_rd_data[CNT_W-1:0] == $past(reg_rd_data[CNT_W-1:0]) + 1'b1));

  // R6
  silent_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rd_data[CNT_W]) |-> $past(!cfg_silent));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (reg_rd_data[CNT_W-1:0] <= CNT_W'(1)));
endmodule

bind tlp_parity_guard tlp_parity_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_eop      (in_eop),
  .cfg_silent  (cfg_silent),
  .cfg_msg_en  (cfg_msg_en),
  .reg_rd      (reg_rd),
  .reg_rd_data (reg_rd_data),
  .msg_req     (msg_req),
  .tlp_bad     (tlp_bad)
);

// File: tb/tlp_parity_guard_test.sv
module tlp_parity_guard_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop, in_eop;
  logic [31:0] in_data;
  logic [3:0]  in_par;
  logic        cfg_silent, cfg_msg_en, reg_rd;
  logic [8:0]  reg_rd_data;
  logic        msg_req, out_valid, out_sop, out_eop;
  logic [31:0] out_data;

  int n_chk  = 0;
  int n_fail = 0;
  int n_msg  = 0;
  logic last_msg;
  logic [33:0] exp_q[$];
  logic [33:0] got_q[$];

  always #5 clk = ~clk;

  tlp_parity_guard uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .in_par(in_par),
    .cfg_silent(cfg_silent), .cfg_msg_en(cfg_msg_en), .reg_rd(reg_rd),
    .reg_rd_data(reg_rd_data), .msg_req(msg_req), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) got_q.push_back({out_sop, out_eop, out_data});
      if (msg_req) n_msg++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] even_par(input logic [31:0] d);
    for (int i = 0; i < 4; i++) even_par[i] = ^d[i*8 +: 8];
  endfunction

  task automatic send(input int len, input int bad_beat, input int base);
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (b == 0);
      in_eop   = (b == len - 1);
      in_data  = {base[15:0], b[15:0]} ^ 32'h5a3c_0000;
      in_par   = even_par(in_data);
      if (b == bad_beat) in_par[b % 4] = ~in_par[b % 4];
      if (bad_beat < 0) exp_q.push_back({in_sop, in_eop, in_data});
    end
    @(negedge clk);
    last_msg = msg_req;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic drain;
    repeat (40) @(negedge clk);
  endtask

  task automatic compare_stream(input string tag);
    chk(got_q.size() == exp_q.size(), tag, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], tag, got_q[i], exp_q[i]);
    got_q.delete(); exp_q.delete();
  endtask

  task automatic do_read(output logic [8:0] v);
    @(negedge clk);
    reg_rd = 1'b1;
    v = reg_rd_data;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    chk(msg_req == 1'b0, "R9 msg_req", msg_req, 0);
    chk(reg_rd_data == 9'd0, "R9 reg_rd_data", reg_rd_data, 0);
  endtask

  task automatic t_good;
    // R1: first beat one cycle after the end beat
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1;
    in_data = 32'hcafe_0001; in_par = even_par(in_data);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    chk(out_valid && out_data == 32'hcafe_0001, "R1 latency", out_data, 32'hcafe_0001);
    drain;
    got_q.delete();
    send(1, -1, 1);
    send(4, -1, 2);
    send(16, -1, 3);
    drain;
    compare_stream("R1 forward");
  endtask

  task automatic t_drop;
    logic [8:0] v;
    cfg_silent = 1'b0; cfg_msg_en = 1'b0;
    n_msg = 0;
    send(3, -1, 10);
    send(5, 0, 11);
    send(5, 2, 12);
    send(5, 4, 13);
    send(2, -1, 14);
    drain;
    compare_stream("R2 drop");
    chk(n_msg == 0, "R5 msg disabled", n_msg, 0);
    do_read(v);
    chk(v == {1'b1, 8'd3}, "R3 R7 count status", v, {1'b1, 8'd3});
    do_read(v);
    chk(v == 9'd0, "R8 cleared", v, 0);
  endtask

  task automatic t_msg;
    logic [8:0] v;
    cfg_silent = 1'b0; cfg_msg_en = 1'b1;
    n_msg = 0;
    send(4, 1, 20);
    chk(last_msg == 1'b1, "R5 pulse cycle", last_msg, 1);
    @(negedge clk);
    chk(msg_req == 1'b0, "R5 one cycle", msg_req, 0);
    drain;
    chk(n_msg == 1, "R5 pulse count", n_msg, 1);
    do_read(v);
  endtask

  task automatic t_silent;
    logic [8:0] v;
    cfg_silent = 1'b1; cfg_msg_en = 1'b1;
    n_msg = 0;
    send(2, 1, 30);
    send(1, 0, 31);
    drain;
    chk(n_msg == 0, "R6 no msg", n_msg, 0);
    do_read(v);
    chk(v == {1'b0, 8'd2}, "R6 no status, R3 counts", v, {1'b0, 8'd2});
    got_q.delete(); exp_q.delete();
    cfg_silent = 1'b0;
  endtask

  task automatic t_sat;
    logic [8:0] v;
    cfg_silent = 1'b0; cfg_msg_en = 1'b1;
    n_msg = 0;
    for (int i = 0; i < 255; i++) send(1, 0, i);
    drain;
    chk(n_msg == 255, "R4 msgs before saturation", n_msg, 255);
    n_msg = 0;
    send(1, 0, 300);
    send(2, 1, 301);
    drain;
    chk(n_msg == 0, "R4 quiet at saturation", n_msg, 0);
    do_read(v);
    chk(v == {1'b1, 8'd255}, "R4 saturated value", v, {1'b1, 8'd255});
    got_q.delete(); exp_q.delete();
  endtask

  task automatic t_rd_collide;
    logic [8:0] v;
    cfg_silent = 1'b1; cfg_msg_en = 1'b0;
    send(1, 0, 40); send(1, 0, 41); send(1, 0, 42);
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1;
    in_data = 32'h0000_00ff; in_par = ~even_par(in_data);
    reg_rd = 1'b1;
    v = reg_rd_data;
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; reg_rd = 1'b0;
    chk(v == {1'b0, 8'd3}, "R8 collide old value", v, 3);
    do_read(v);
    chk(v == {1'b0, 8'd1}, "R8 collide leaves 1", v, 1);
    drain;
    chk(got_q.size() == 0, "R2 nothing out", got_q.size(), 0);
    got_q.delete(); exp_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    in_data = '0; in_par = '0; cfg_silent = 1'b0; cfg_msg_en = 1'b0; reg_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_good;
    t_drop;
    t_msg;
    t_silent;
    t_sat;
    t_rd_collide;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule